// File: doc/BRIEF.md
# Four-Lane Serial Peripheral Master

This block is a serial peripheral master for a register-mapped host. The host raises `go_i` and holds it high. The block then shifts out the low `XFER_LEN` bits of a 32-bit transmit word on one shared MOSI line, under one shared serial clock. The same serial clock reaches up to four slave devices. Each slave returns data on its own MISO input. All four inputs are sampled on the same edges into four separate 32-bit receive words, and a lane with no device is tied low.

A 3-bit select sets the serial clock rate. Each half period of the serial clock lasts `2^sel` system clocks, so code 0 gives half the system clock rate and each higher code halves the rate again. The block drives one active-high chip select, and logic outside the block masks and inverts it for each device. The block raises `done_o` for one cycle while `go_i` is still held, so the host can hold back its bus acknowledge until the transfer ends. For a register read, the host sets the read flag at bit 23 of the transmit word, with a byte count at [22:21], a register address at [14:8] and data at [7:0]. The slave answers in the last eight bit times of the transfer, so the byte it returns appears at bits [7:0] of that lane's receive word.

Top module: `spi_ml_master`

## Requirements
- R1: While reset is asserted and directly after it, `cs_o`, `sclk_o`, `mosi_o` and `done_o` are 0, `bit_num_o` is 0 and every receive word is 0.
- R2: A transfer shifts `tx_word_i[XFER_LEN-1:0]` out on `mosi_o`, most significant bit first, over exactly `XFER_LEN` rising edges of `sclk_o`. `mosi_o` changes only on a falling edge of `sclk_o`, never while `sclk_o` is high.
- R3: Each half period of `sclk_o` lasts exactly `2^div_sel_i` system clocks. The block captures `div_sel_i` when the transfer starts, and a change to it during the transfer has no effect.
- R4: For each lane L, the block samples `miso_i[L]` on every rising edge of `sclk_o` and shifts it into bit 0 of `rx_word_o[L]`, moving the earlier bits left. Each receive word is cleared when a transfer starts, so after the transfer it holds the `XFER_LEN` bits the slave sent, zero-extended.
- R5: The first rising edge of `sclk_o` comes exactly one half period after `cs_o` rises. `cs_o` falls exactly one half period after the last falling edge of `sclk_o`.
- R6: `done_o` is high for exactly one system clock, in the same cycle that `cs_o` first reads low after the transfer, while `go_i` is still high.
- R7: While a transfer is running, the state of `go_i` is ignored. If `go_i` stays high after `done_o`, no new transfer starts until `go_i` has been seen low.
- R8: `bit_num_o` reads k at the k-th rising edge of `sclk_o` (counting from 0), steps by one at each falling edge, and never exceeds `XFER_LEN-1`.
- R9: While `cs_o` is low, `sclk_o` and `mosi_o` are low.
- R10: In a read transfer (transmit bit 23 = 1), the byte the slave drives in the last eight bit times appears in bits [7:0] of that lane's receive word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Transfer request, held high until done_o |
| div_sel_i | input | DIV_W | Serial clock rate select, half period 2^code clocks |
| tx_word_i | input | DATA_W | Transmit word, low XFER_LEN bits are sent |
| miso_i | input | LANES | One serial input per slave lane |
| done_o | output | 1 | One-cycle completion strobe |
| bit_num_o | output | BIT_W | Index of the current bit in the transfer |
| rx_word_o | output | LANES x DATA_W | Receive word per lane |
| cs_o | output | 1 | Common chip select, active high |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial output shared by all lanes |

## Verification
The bench builds the block with its defaults: a 24-bit transfer, four lanes, 32-bit words and a 3-bit divider select. With these values every divider code, including code 7 with a 128-clock half period, fits in a short run. Because 24 is less than 32, any receive bits left over from an earlier transfer would show up in bits [31:24], so the clear at the start of each transfer can be seen. A behavioural slave on each lane drives a distinct random pattern and records MOSI. A monitor times the chip-select lead and trail, each half period and the done strobe against the selected code.

// File: rtl/spi_ml_pkg.sv
package spi_ml_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TRAIL,
    ST_DONE,
    ST_HOLD
  } spi_ml_state_e;
endpackage

// File: rtl/spi_ml_clkdiv.sv
module spi_ml_clkdiv #(
  parameter int DIV_W = 3,
  localparam int CNT_W = 2 ** DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] sel_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // half period of 2^sel clocks
  assign lim    = (CNT_W'(1) << sel_q) - CNT_W'(1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else if (restart_i) begin
      sel_q <= sel_i;
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/spi_ml_rx_lane.sv
module spi_ml_rx_lane #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic [DATA_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       word_o <= '0;
    else if (clr_i)    word_o <= '0;
    else if (sample_i) word_o <= {word_o[DATA_W-2:0], miso_i};
  end
endmodule

// File: rtl/spi_ml_master.sv
module spi_ml_master
  import spi_ml_pkg::*;
#(
  parameter int XFER_LEN = 24,
  parameter int DATA_W   = 32,
  parameter int LANES    = 4,
  parameter int DIV_W    = 3,
  localparam int BIT_W   = (XFER_LEN > 1) ? $clog2(XFER_LEN) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         go_i,
  input  logic [DIV_W-1:0]             div_sel_i,
  input  logic [DATA_W-1:0]            tx_word_i,
  input  logic [LANES-1:0]             miso_i,
  output logic                         done_o,
  output logic [BIT_W-1:0]             bit_num_o,
  output logic [LANES-1:0][DATA_W-1:0] rx_word_o,
  output logic                         cs_o,
  output logic                         sclk_o,
  output logic                         mosi_o
);
  spi_ml_state_e       st_q;
  logic [XFER_LEN-1:0] sh_q;
  logic [BIT_W-1:0]    bit_q;
  logic                cs_q, sclk_q;
  logic                tick, start, run, sample, last_bit;

  assign start    = (st_q == ST_IDLE) && go_i;
  assign run      = (st_q == ST_LEAD) || (st_q == ST_HIGH) ||
                    (st_q == ST_LOW)  || (st_q == ST_TRAIL);
  assign sample   = tick && ((st_q == ST_LEAD) || (st_q == ST_LOW));
  assign last_bit = (bit_q == BIT_W'(XFER_LEN - 1));

  spi_ml_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(start),
    .run_i    (run),
    .sel_i    (div_sel_i),
    .tick_o   (tick)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    spi_ml_rx_lane #(.DATA_W(DATA_W)) u_rx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (start),
      .sample_i(sample),
      .miso_i  (miso_i[l]),
      .word_o  (rx_word_o[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      bit_q  <= '0;
      cs_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go_i) begin
          st_q  <= ST_LEAD;
          cs_q  <= 1'b1;
          sh_q  <= tx_word_i[XFER_LEN-1:0];
          bit_q <= '0;
        end
        ST_LEAD, ST_LOW: if (tick) begin
          sclk_q <= 1'b1;
          st_q   <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk_q <= 1'b0;
          if (last_bit) st_q <= ST_TRAIL;
          else begin
            bit_q <= bit_q + BIT_W'(1);
            sh_q  <= sh_q << 1;
            st_q  <= ST_LOW;
          end
        end
        ST_TRAIL: if (tick) begin
          cs_q <= 1'b0;
          st_q <= ST_DONE;
        end
        ST_DONE: st_q <= go_i ? ST_HOLD : ST_IDLE;
        ST_HOLD: if (!go_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o    = (st_q == ST_DONE);
  assign bit_num_o = bit_q;
  assign cs_o      = cs_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = cs_q & sh_q[XFER_LEN-1];
endmodule

// File: rtl/spi_ml_master_chk.sv
module spi_ml_master_chk #(
  parameter int XFER_LEN = 24,
  parameter int DATA_W   = 32,
  parameter int LANES    = 4,
  parameter int BIT_W    = 5
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         done_o,
  input logic [BIT_W-1:0]             bit_num_o,
  input logic [LANES-1:0][DATA_W-1:0] rx_word_o,
  input logic                         cs_o,
  input logic                         sclk_o,
  input logic                         mosi_o
);
  p_idle_lines_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> (!sclk_o && !mosi_o));

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_at_cs_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(cs_o));

  p_mosi_hold_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  p_rx_cleared_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> (rx_word_o == '0));

  p_bit_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o && $past(cs_o) && !$stable(bit_num_o)) |->
      (bit_num_o == $past(bit_num_o) + BIT_W'(1)));

  always @(posedge clk_i)
    if (rst_ni) p_bit_max_r8: assert (32'(bit_num_o) < XFER_LEN);
endmodule

bind spi_ml_master spi_ml_master_chk #(
  .XFER_LEN(XFER_LEN), .DATA_W(DATA_W), .LANES(LANES), .BIT_W(BIT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .done_o   (done_o),
  .bit_num_o(bit_num_o),
  .rx_word_o(rx_word_o),
  .cs_o     (cs_o),
  .sclk_o   (sclk_o),
  .mosi_o   (mosi_o)
);

// File: tb/spi_ml_master_bench.sv
`timescale 1ns/1ps
module spi_ml_master_bench;
  localparam int LEN = 24;
  localparam int DW  = 32;
  localparam int NL  = 4;
  localparam int DVW = 3;
  localparam int BW  = $clog2(LEN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [DVW-1:0] div_sel = '0;
  logic [DW-1:0] tx = '0;
  logic [NL-1:0] miso = '0;
  logic done, cs, sclk, mosi;
  logic [BW-1:0] bit_num;
  logic [NL-1:0][DW-1:0] rx;

  always #4 clk = ~clk;

  spi_ml_master u_spi_ml_master (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .div_sel_i(div_sel),
    .tx_word_i(tx), .miso_i(miso), .done_o(done), .bit_num_o(bit_num),
    .rx_word_o(rx), .cs_o(cs), .sclk_o(sclk), .mosi_o(mosi)
  );

  int checks = 0, fails = 0;
  logic [LEN-1:0] pat [NL];

  // monitor / slave model state
  int t = 0, n_rise = 0, idx = 0, n_cs_rise = 0, n_done = 0;
  int t_cs_rise = 0, t_first = 0, t_prev = 0, t_last_fall = 0, t_cs_fall = 0, t_done = 0;
  int bad_per = 0, bad_mosi = 0, bad_bn = 0, h_exp = 1;
  logic [LEN-1:0] mcap = '0;
  logic cs_p = 1'b0, sclk_p = 1'b0, mosi_p = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_rx(input logic [LEN-1:0] p);
    return DW'(p);
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      t++;
      if (cs && !cs_p) begin
        t_cs_rise = t; n_rise = 0; idx = 0; mcap = '0; n_cs_rise++;
        bad_per = 0; bad_mosi = 0; bad_bn = 0;
      end
      if (sclk && !sclk_p) begin
        if (n_rise == 0) t_first = t;
        else if (t - t_prev != 2 * h_exp) bad_per++;
        t_prev = t;
        if (int'(bit_num) != n_rise) bad_bn++;
        mcap = {mcap[LEN-2:0], mosi};
        n_rise++;
      end
      if (!sclk && sclk_p) begin
        t_last_fall = t;
        idx++;
      end
      if (sclk && sclk_p && (mosi != mosi_p)) bad_mosi++;
      if (!cs && cs_p) t_cs_fall = t;
      if (done) begin t_done = t; n_done++; end
      for (int l = 0; l < NL; l++)
        miso[l] = (cs && idx < LEN) ? pat[l][LEN-1-idx] : 1'b0;
      cs_p = cs; sclk_p = sclk; mosi_p = mosi;
    end
  end

  task automatic run_xfer(input logic [DW-1:0] w, input logic [DVW-1:0] sel,
                          input bit glitch, input bit chg_sel);
    int cs0, dn0;
    @(negedge clk);
    for (int l = 0; l < NL; l++) pat[l] = LEN'($urandom);
    tx = w; div_sel = sel; h_exp = 1 << sel;
    cs0 = n_cs_rise; dn0 = n_done;
    go = 1'b1;
    repeat (3) @(negedge clk);
    if (chg_sel) div_sel = ~sel;
    if (glitch) begin
      go = 1'b0; repeat (2) @(negedge clk); go = 1'b1;
    end
    while (!done) @(negedge clk);
    repeat (12) @(negedge clk);      // go held high after done
    chk(n_cs_rise == cs0 + 1, "R7 single start", n_cs_rise - cs0, 1);
    chk(n_done == dn0 + 1, "R6 done width", n_done - dn0, 1);
    chk(t_done == t_cs_fall, "R6 done with cs fall", t_done, t_cs_fall);
    chk(mcap == w[LEN-1:0] && n_rise == LEN, "R2 mosi bits", mcap, w[LEN-1:0]);
    chk(bad_mosi == 0, "R2 mosi stable while high", bad_mosi, 0);
    chk(bad_per == 0, "R3 half period", bad_per, 0);
    chk(t_first - t_cs_rise == h_exp, "R5 cs lead", t_first - t_cs_rise, h_exp);
    chk(t_cs_fall - t_last_fall == h_exp, "R5 cs trail", t_cs_fall - t_last_fall, h_exp);
    chk(bad_bn == 0, "R8 bit number", bad_bn, 0);
    for (int l = 0; l < NL; l++)
      chk(rx[l] == exp_rx(pat[l]), "R4 lane rx", rx[l], exp_rx(pat[l]));
    if (w[23]) chk(rx[1][7:0] == pat[1][7:0], "R10 read byte", rx[1][7:0], pat[1][7:0]);
    chk(!sclk && !mosi, "R9 idle lines", {sclk, mosi}, 0);
    go = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int l = 0; l < NL; l++) pat[l] = '0;
    repeat (3) @(negedge clk);
    chk(!cs && !sclk && !mosi && !done, "R1 reset lines", {cs, sclk, mosi, done}, 0);
    chk(rx == '0 && bit_num == '0, "R1 reset regs", rx[0], 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cs && !sclk && !mosi && !done && rx == '0, "R1 after reset", cs, 0);
    // directed cases
    run_xfer(32'h00A5_C35A, 3'd0, 1'b0, 1'b0);
    run_xfer(32'h0080_1234, 3'd2, 1'b0, 1'b1);   // read flag, sel change ignored (R3)
    run_xfer(32'h00FF_FFFF, 3'd1, 1'b1, 1'b0);   // go glitch while busy (R7)
    run_xfer(32'h0000_0001, 3'd7, 1'b0, 1'b0);   // slowest rate
    // random cases
    for (int i = 0; i < 8; i++)
      run_xfer($urandom, DVW'($urandom_range(0, 4)), 1'($urandom), 1'($urandom));
    // R7: after go is dropped, a new request starts again
    chk(!cs, "R7 idle before restart", cs, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule